// File: doc/BRIEF.md
# Register-Loaded Packet Stream Transmitter

This block lets a processor build outgoing packets one 32-bit word at a time over a small register bus and sends them out on an AXI4-Stream master port. Each data-register write appends one word to an internal word buffer. The packet is not visible on the stream until the processor writes its byte count to the length register. That write marks every word written since the previous commit as one packet. Committed packets leave in commit order. TLAST is set on the final word, and the stream obeys TVALID/TREADY backpressure.

The processor polls a vacancy register before writing. It reads four words fewer than the buffer depth when the buffer is empty. A keyed write to a reset register clears the whole transmit path. Single-cycle event outputs report a finished packet, a word dropped on a full buffer, a length that does not match the words written, a finished reset, and the occupancy crossing a high and a low watermark. An external interrupt register file is expected to collect these events.

Top module: `mm_stream_tx`

## Requirements
- R1: After the synchronous reset, m_tvalid is low, every event output is low, and the vacancy register (bus_addr 3, read on bus_rdata) reads DEPTH-4.
- R2: A bus write to address 0 appends bus_wdata to the buffer and lowers vacancy by one. Vacancy always equals DEPTH-4 minus the stored words, and m_tvalid stays low until a packet is committed.
- R3: A write to address 1 with byte count L, when L equals 4 times the uncommitted word count N, commits those N words as one packet. The words stream in write order with m_tlast on word L/4, and packets leave in commit order.
- R4: While m_tvalid is high and m_tready is low, m_tvalid stays high and m_tdata and m_tlast hold their values.
- R5: evt_tx_done is high for exactly the one cycle after the clock edge that takes a word with m_tlast high.
- R6: A data write when vacancy is zero, judged on the occupancy before that edge, drops the word and raises evt_overrun for the following cycle.
- R7: A length write whose byte count is not a multiple of 4, or not 4 times N, or that arrives with N equal to 0, raises evt_len_err for the following cycle. If N is nonzero, the N words are still sent as one packet with m_tlast on the last word written.
- R8: Writing exactly 0x000000A5 to address 2 empties the buffer, drops committed and uncommitted packets, and ends any packet in flight. evt_rst_done is high in the following cycle and vacancy reads DEPTH-4 again.
- R9: A write of any other value to address 2, and any write to address 3, changes no state: vacancy, stream and events stay as they were.
- R10: evt_prog_full pulses for one cycle when occupancy goes from below PFULL_TH to PFULL_TH or above. evt_prog_empty pulses for one cycle when occupancy goes from above PEMPTY_TH to PEMPTY_TH or below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 data, 1 length, 2 reset key, 3 vacancy |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Vacancy in words when bus_addr is 3, else zero |
| m_tdata | output | 32 | Stream data |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready from the sink |
| m_tlast | output | 1 | Final word of a packet |
| evt_tx_done | output | 1 | Packet fully sent |
| evt_overrun | output | 1 | Word dropped on a full buffer |
| evt_len_err | output | 1 | Committed length mismatch |
| evt_rst_done | output | 1 | Keyed reset finished |
| evt_prog_full | output | 1 | Occupancy rose to the high watermark |
| evt_prog_empty | output | 1 | Occupancy fell to the low watermark |

## Verification
The commit path is tried with directed packets held back by a stalled sink. Vacancy, m_tvalid before the commit, and a stalled word are checked there, which separates buffering from sending. Fills to exactly the limit and one word past it separate the overrun boundary from the high watermark. Short, odd and empty byte counts separate mismatch handling from a good commit. Many random packets of one to six words under random TREADY show that word order, TLAST placement and completion events survive backpressure. Keyed and wrong-key reset writes with data pending show that only the exact key clears the path.

// File: rtl/mmtx_pkg.sv
// Shared definitions for the register-loaded stream transmitter.
// Assumes a 32-bit register bus with a 2-bit word address.
package mmtx_pkg;
    localparam int WORD_W = 32;

    // Register select values seen on bus_addr
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_RST  = 2'd2,
        SEL_VAC  = 2'd3
    } reg_sel_e;

    // Only this exact value written to SEL_RST clears the transmit path
    localparam logic [WORD_W-1:0] CLEAR_KEY = 32'h0000_00A5;
endpackage

// File: rtl/mmtx_fifo.sv
// Generic synchronous FIFO with a synchronous clear.
// Assumes DEPTH is a power of two, push never comes when full and pop never
// comes when empty (both guarded by the caller). Clear overrides push/pop.
module mmtx_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    cnt
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    // Storage write on push
    always_ff @(posedge clk) begin
        if (push && !clr) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and fill-count update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + AW'(1);
            end
            if (pop) begin
                rd_ptr <= rd_ptr + AW'(1);
            end
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    // Head of queue is always presented
    assign dout = mem[rd_ptr];
endmodule

// File: rtl/mmtx_commit.sv
// Bus-side commit logic: decodes register writes, pushes data words, counts
// uncommitted words, commits packets on a length write and raises the
// overrun, length-mismatch and reset-done events.
// Assumes one bus write per cycle; usable capacity is DEPTH-4 words.
module mmtx_commit
    import mmtx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [CW-1:0]     occ,
    output logic              wb_push,
    output logic [WORD_W-1:0] wb_din,
    output logic              lq_push,
    output logic [CW-1:0]     lq_din,
    output logic              clr,
    output logic              evt_overrun,
    output logic              evt_len_err,
    output logic              evt_rst_done
);
    localparam logic [CW-1:0] CAP = CW'(DEPTH - 4);

    logic [CW-1:0] pend;
    logic          wr_data;
    logic          wr_len;
    logic          full;
    logic          len_ok;

    // Register write decode and commit decision
    always_comb begin
        wr_data = bus_we && (bus_addr == SEL_DATA);
        wr_len  = bus_we && (bus_addr == SEL_LEN);
        clr     = bus_we && (bus_addr == SEL_RST) && (bus_wdata == CLEAR_KEY);
        full    = (occ >= CAP);
        wb_push = wr_data && !full;
        wb_din  = bus_wdata;
        len_ok  = (bus_wdata[1:0] == 2'b00) &&
                  (bus_wdata[WORD_W-1:2] == (WORD_W-2)'(pend)) &&
                  (pend != '0);
        lq_push = wr_len && (pend != '0);
        lq_din  = pend;
    end

    // Count of words written since the last commit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pend <= '0;
        end else if (wr_len) begin
            pend <= '0;
        end else if (wb_push) begin
            pend <= pend + CW'(1);
        end
    end

    // Single-cycle bus-side events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_overrun  <= 1'b0;
            evt_len_err  <= 1'b0;
            evt_rst_done <= 1'b0;
        end else begin
            evt_overrun  <= wr_data && full;
            evt_len_err  <= wr_len && !len_ok;
            evt_rst_done <= clr;
        end
    end
endmodule

// File: rtl/mmtx_stream.sv
// Stream sequencer: presents the head word while a committed packet exists,
// counts words sent in the current packet, flags the last one and reports
// packet completion.
// Assumes every committed length is at least one and its words are buffered.
module mmtx_stream
    import mmtx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              pkt_avail,
    input  logic [CW-1:0]     pkt_len,
    input  logic [WORD_W-1:0] head_word,
    input  logic              m_tready,
    output logic [WORD_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    output logic              word_pop,
    output logic              pkt_pop,
    output logic              evt_tx_done
);
    logic [CW-1:0] sent;

    // Stream outputs and pop strobes
    always_comb begin
        m_tvalid = pkt_avail;
        m_tdata  = head_word;
        m_tlast  = pkt_avail && (sent == pkt_len - CW'(1));
        word_pop = m_tvalid && m_tready;
        pkt_pop  = word_pop && m_tlast;
    end

    // Words already sent from the packet at the head
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sent <= '0;
        end else if (pkt_pop) begin
            sent <= '0;
        end else if (word_pop) begin
            sent <= sent + CW'(1);
        end
    end

    // Completion pulse after the final handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_tx_done <= 1'b0;
        end else begin
            evt_tx_done <= pkt_pop;
        end
    end
endmodule

// File: rtl/mmtx_level.sv
// Watermark crossing detector: compares the occupancy now with the value one
// cycle earlier and pulses on an upward crossing of the high mark or a
// downward crossing of the low mark.
// Assumes occupancy is a registered count that resets to zero.
module mmtx_level #(
    parameter int DEPTH     = 16,
    parameter int PFULL_TH  = 8,
    parameter int PEMPTY_TH = 2,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] occ,
    output logic          evt_prog_full,
    output logic          evt_prog_empty
);
    localparam logic [CW-1:0] HI = CW'(PFULL_TH);
    localparam logic [CW-1:0] LO = CW'(PEMPTY_TH);

    logic [CW-1:0] occ_prev;

    // Previous-cycle occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_prev <= '0;
        end else begin
            occ_prev <= occ;
        end
    end

    // Crossing detection
    always_comb begin
        evt_prog_full  = (occ_prev < HI) && (occ >= HI);
        evt_prog_empty = (occ_prev > LO) && (occ <= LO);
    end
endmodule

// File: rtl/mm_stream_tx.sv
// Register-loaded packet stream transmitter, top level.
// Data words and packet lengths share one buffer depth; the length queue is
// as deep as the word buffer so it can never overflow (each packet holds at
// least one word). Assumes DEPTH is a power of two and greater than 4.
module mm_stream_tx
    import mmtx_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int PFULL_TH  = 8,
    parameter int PEMPTY_TH = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [31:0] m_tdata,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic        m_tlast,
    output logic        evt_tx_done,
    output logic        evt_overrun,
    output logic        evt_len_err,
    output logic        evt_rst_done,
    output logic        evt_prog_full,
    output logic        evt_prog_empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP = CW'(DEPTH - 4);

    logic              clr;
    logic              wb_push;
    logic [WORD_W-1:0] wb_din;
    logic [WORD_W-1:0] wb_head;
    logic [CW-1:0]     wb_cnt;
    logic              lq_push;
    logic [CW-1:0]     lq_din;
    logic [CW-1:0]     lq_head;
    logic [CW-1:0]     lq_cnt;
    logic              word_pop;
    logic              pkt_pop;

    mmtx_commit #(.DEPTH(DEPTH)) u_commit (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .occ          (wb_cnt),
        .wb_push      (wb_push),
        .wb_din       (wb_din),
        .lq_push      (lq_push),
        .lq_din       (lq_din),
        .clr          (clr),
        .evt_overrun  (evt_overrun),
        .evt_len_err  (evt_len_err),
        .evt_rst_done (evt_rst_done)
    );

    mmtx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_words (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (wb_push),
        .din   (wb_din),
        .pop   (word_pop),
        .dout  (wb_head),
        .cnt   (wb_cnt)
    );

    mmtx_fifo #(.WIDTH(CW), .DEPTH(DEPTH)) u_lengths (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (lq_push),
        .din   (lq_din),
        .pop   (pkt_pop),
        .dout  (lq_head),
        .cnt   (lq_cnt)
    );

    mmtx_stream #(.DEPTH(DEPTH)) u_stream (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .pkt_avail   (lq_cnt != '0),
        .pkt_len     (lq_head),
        .head_word   (wb_head),
        .m_tready    (m_tready),
        .m_tdata     (m_tdata),
        .m_tvalid    (m_tvalid),
        .m_tlast     (m_tlast),
        .word_pop    (word_pop),
        .pkt_pop     (pkt_pop),
        .evt_tx_done (evt_tx_done)
    );

    mmtx_level #(.DEPTH(DEPTH), .PFULL_TH(PFULL_TH), .PEMPTY_TH(PEMPTY_TH)) u_level (
        .clk            (clk),
        .rst_n          (rst_n),
        .occ            (wb_cnt),
        .evt_prog_full  (evt_prog_full),
        .evt_prog_empty (evt_prog_empty)
    );

    // Vacancy read mux
    assign bus_rdata = (bus_addr == SEL_VAC) ? 32'(CAP - wb_cnt) : 32'd0;
endmodule

// File: rtl/mmtx_checker.sv
// Property checker for mm_stream_tx, attached with bind below.
module mmtx_checker
    import mmtx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_we,
    input logic [1:0]    bus_addr,
    input logic [31:0]   bus_wdata,
    input logic [CW-1:0] occ,
    input logic [31:0]   m_tdata,
    input logic          m_tvalid,
    input logic          m_tready,
    input logic          m_tlast,
    input logic          evt_tx_done,
    input logic          evt_overrun,
    input logic          evt_rst_done
);
    localparam logic [CW-1:0] CAP = CW'(DEPTH - 4);

    logic key_wr;
    assign key_wr = bus_we && (bus_addr == SEL_RST) && (bus_wdata == CLEAR_KEY);

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) occ <= CAP); // R2
    AST_VALID_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n) m_tvalid |-> occ != '0); // R3
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n) m_tvalid && !m_tready && !key_wr |=> m_tvalid); // R4
    AST_BEAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n) m_tvalid && !m_tready && !key_wr |=> $stable(m_tdata) && $stable(m_tlast)); // R4
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) evt_tx_done |-> $past(m_tvalid && m_tready && m_tlast)); // R5
    AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n) bus_we && bus_addr == SEL_DATA && occ == CAP |=> evt_overrun); // R6
    AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) key_wr |=> evt_rst_done && occ == '0 && !m_tvalid); // R8
    AST_DONE_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n) evt_rst_done |-> $past(key_wr)); // R9
endmodule

bind mm_stream_tx mmtx_checker #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .occ          (wb_cnt),
    .m_tdata      (m_tdata),
    .m_tvalid     (m_tvalid),
    .m_tready     (m_tready),
    .m_tlast      (m_tlast),
    .evt_tx_done  (evt_tx_done),
    .evt_overrun  (evt_overrun),
    .evt_rst_done (evt_rst_done)
);

// File: tb/mm_stream_tx_test.sv
`timescale 1ns/1ps
module mm_stream_tx_test;
    localparam int DEPTH = 16;
    localparam int CAP   = DEPTH - 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [31:0] m_tdata;
    logic        m_tvalid;
    logic        m_tready = 1'b0;
    logic        m_tlast;
    logic        evt_tx_done, evt_overrun, evt_len_err, evt_rst_done;
    logic        evt_prog_full, evt_prog_empty;

    mm_stream_tx #(.DEPTH(DEPTH), .PFULL_TH(8), .PEMPTY_TH(2)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .m_tdata(m_tdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
        .evt_tx_done(evt_tx_done), .evt_overrun(evt_overrun),
        .evt_len_err(evt_len_err), .evt_rst_done(evt_rst_done),
        .evt_prog_full(evt_prog_full), .evt_prog_empty(evt_prog_empty)
    );

    always #2 clk = ~clk;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] exp_data[$];
    bit          exp_last[$];
    logic [31:0] pend_q[$];
    int          exp_occ = 0;
    bit          done_due = 1'b0;
    bit          rand_ready = 1'b0;
    int          pf_cnt = 0;
    int          pe_cnt = 0;

    task automatic check_eq(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected overrun from model occupancy
    function automatic bit model_full();
        return exp_occ >= CAP;
    endfunction

    // Expected length error from byte count and pending words
    function automatic bit model_len_err(input int len, input int n);
        return !((len % 4 == 0) && (len / 4 == n) && (n != 0));
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] d);
        bit ovf;
        ovf = model_full();
        if (!ovf) begin
            pend_q.push_back(d);
            exp_occ++;
        end
        wr(2'd0, d);
        check_eq("R6 overrun event", evt_overrun, ovf);
    endtask

    task automatic commit(input int len);
        bit err;
        int n;
        n = pend_q.size();
        err = model_len_err(len, n);
        for (int i = 0; i < n; i++) begin
            exp_data.push_back(pend_q[i]);
            exp_last.push_back(i == n - 1);
        end
        pend_q.delete();
        wr(2'd1, len);
        check_eq(err ? "R7 length error event" : "R3 clean commit", evt_len_err, err);
    endtask

    task automatic get_vac(output int v);
        bus_addr = 2'd3;
        #1;
        v = bus_rdata;
        @(negedge clk);
    endtask

    task automatic drain();
        rand_ready = 1'b0;
        m_tready = 1'b1;
        for (int i = 0; i < 2000 && exp_data.size() > 0; i++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check_eq("R3 all words delivered", exp_data.size(), 0);
    endtask

    // Sink ready driver
    initial begin
        forever begin
            @(negedge clk);
            if (rand_ready) m_tready = ($urandom % 4) != 0;
        end
    end

    // Stream scoreboard and completion check
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                check_eq("R5 tx_done pulse", evt_tx_done, done_due);
                done_due = 1'b0;
                if (evt_prog_full) pf_cnt++;
                if (evt_prog_empty) pe_cnt++;
                if (m_tvalid && m_tready) begin
                    if (exp_data.size() == 0) begin
                        check_eq("R3 unexpected word", m_tdata, 0);
                        n_bad++;
                    end else begin
                        check_eq("R3 word data", m_tdata, exp_data.pop_front());
                        done_due = exp_last.pop_front();
                        check_eq("R3 tlast position", m_tlast, done_due);
                        exp_occ--;
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int v;
        logic [31:0] held;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_eq("R1 tvalid after reset", m_tvalid, 0);
        check_eq("R1 events after reset", {evt_tx_done, evt_overrun, evt_len_err,
                 evt_rst_done, evt_prog_full, evt_prog_empty}, 0);
        get_vac(v);
        check_eq("R1 vacancy after reset", v, CAP);

        // R2 buffering without commit, then R3/R4 single packet
        push_word(32'hCAFE_0001);
        push_word(32'hCAFE_0002);
        push_word(32'hCAFE_0003);
        get_vac(v);
        check_eq("R2 vacancy after three words", v, CAP - 3);
        check_eq("R2 no valid before commit", m_tvalid, 0);
        commit(12);
        check_eq("R3 valid after commit", m_tvalid, 1);
        held = m_tdata;
        @(negedge clk);
        check_eq("R4 data held under stall", m_tdata, held);
        check_eq("R4 valid held under stall", m_tvalid, 1);
        drain();

        // R6/R10 fill to the limit and past it
        m_tready = 1'b0;
        pf_cnt = 0; pe_cnt = 0;
        for (int i = 0; i < CAP; i++) begin
            push_word(32'h1000 + i);
            if (i == 7) check_eq("R10 prog full on reaching mark", evt_prog_full, 1);
        end
        push_word(32'hDEAD_BEEF);
        get_vac(v);
        check_eq("R6 vacancy zero when full", v, 0);
        commit(CAP * 4);
        drain();
        check_eq("R10 one prog full pulse", pf_cnt, 1);
        check_eq("R10 one prog empty pulse", pe_cnt, 1);

        // R7 mismatch forms
        push_word(32'hA1); push_word(32'hA2);
        commit(12);
        drain();
        commit(8);
        check_eq("R7 no packet from empty commit", m_tvalid, 0);
        push_word(32'hB1); push_word(32'hB2);
        commit(10);
        drain();
        push_word(32'hC1);
        commit(4);
        drain();

        // R9 ignored writes, R8 keyed clear
        m_tready = 1'b0;
        push_word(32'hD1); push_word(32'hD2); push_word(32'hD3);
        commit(12);
        push_word(32'hD4); push_word(32'hD5);
        wr(2'd2, 32'h0000_005A);
        check_eq("R9 wrong key no reset event", evt_rst_done, 0);
        wr(2'd3, 32'h0000_FFFF);
        get_vac(v);
        check_eq("R9 vacancy unchanged by ignored writes", v, CAP - 5);
        check_eq("R9 packet survives wrong key", m_tvalid, 1);
        wr(2'd2, 32'h0000_00A5);
        check_eq("R8 reset done event", evt_rst_done, 1);
        exp_data.delete(); exp_last.delete(); pend_q.delete(); exp_occ = 0;
        get_vac(v);
        check_eq("R8 vacancy restored", v, CAP);
        check_eq("R8 stream cleared", m_tvalid, 0);
        push_word(32'hE1);
        commit(4);
        drain();

        // R3/R4 random packets under random backpressure
        rand_ready = 1'b1;
        for (int p = 0; p < 40; p++) begin
            int n;
            n = 1 + ($urandom % 6);
            for (int w = 0; w < 2000 && exp_occ + n > CAP; w++) @(negedge clk);
            for (int k = 0; k < n; k++) push_word($urandom);
            commit(n * 4);
        end
        drain();
        get_vac(v);
        check_eq("R2 vacancy after random traffic", v, CAP);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule